// File: doc/BRIEF.md
# Taken-Branch Micro Target Buffer

This block is a small, fully associative store of recently taken branches that sits beside the instruction fetch stage. In every fetch cycle it compares the fetch address with all stored branch addresses. On a match, it returns the remembered target in that same cycle. Fetch can therefore redirect at once, without waiting a cycle for the slower main predictor.

The buffer learns only from resolved branches that were taken. A resolved not-taken branch removes any entry for its address. The main predictor arrives later than this block and has the final say. When it disagrees with a guess made here, an override port invalidates the entry that made the wrong guess.

If the buffer is full, new branches replace entries in round-robin order. A flush input empties the whole buffer in a single cycle.

Top module: `micro_target_buffer`

## Requirements
- R1: While reset (`rstN` low, sampled synchronously) is held, every entry is invalidated and the replacement pointer returns to entry 0, even if an update is presented at the same time. After reset, no fetch address hits.
- R2: Lookup is combinational. `lookupHit` is high in the same cycle as `fetchValid` exactly when a valid entry's full stored address equals `fetchPc`, and `lookupTarget` then carries that entry's target. `lookupHit` is never high while `fetchValid` is low.
- R3: An update with `updValid` and `updTaken` high, for an address that is not stored, writes a new entry. This entry is visible to lookups from the next cycle. It goes into the lowest-numbered invalid entry.
- R4: An update with `updTaken` low, for an address that is not stored, changes no entry.
- R5: A taken update for an address that is already stored rewrites only that entry's target. No second entry is made, so at most one entry ever matches a given address.
- R6: A not-taken update for an address that is stored invalidates that entry from the next cycle.
- R7: `ovrValid` invalidates the entry whose address equals `ovrPc`. If an update for the same address arrives in the same cycle, the override wins and the update is dropped. An update for a different address still proceeds.
- R8: When all entries are valid, a taken update for a new address replaces the entry at the round-robin pointer. The pointer starts at entry 0, advances by one per such replacement, and wraps after the last entry. Filling a free entry or rewriting a stored one leaves the pointer unchanged.
- R9: `flush` invalidates every entry in one cycle and returns the pointer to entry 0. It takes priority over any update or override in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| fetchValid | input | 1 | Fetch address is being looked up this cycle |
| fetchPc | input | PC_W | Fetch address |
| lookupHit | output | 1 | Stored taken branch matches the fetch address |
| lookupTarget | output | PC_W | Predicted target on a hit, zero otherwise |
| updValid | input | 1 | A resolved branch is reported |
| updPc | input | PC_W | Address of the resolved branch |
| updTarget | input | PC_W | Resolved target |
| updTaken | input | 1 | Branch resolved taken |
| ovrValid | input | 1 | Main predictor overruled a guess |
| ovrPc | input | PC_W | Address whose guess was overruled |
| flush | input | 1 | Invalidate all entries |

## Verification
A wrong internal state in this block shows up at the lookup port. It can be a stale valid bit, a target written to the wrong entry, or a duplicate entry. Because lookup is combinational, the error appears in the first cycle after the update that caused it: as a hit that should be a miss, a miss that should be a hit, or a wrong target.

A misplaced round-robin pointer is harder to see. It shows only once the buffer is full: after the next replacement, the wrong address disappears. The bench therefore sweeps every address it has used after each fill and replacement phase.

// File: rtl/mtb_pkg.sv
package mtb_pkg;

  // Strobes issued by the control to the entry storage for one cycle
  typedef struct packed {
    logic flushAll;       // clear every valid bit
    logic writeEntry;     // write tag/target at the selected index, set valid
    logic clearUpdMatch;  // clear the entry matching the update address
    logic clearOvrMatch;  // clear the entry matching the override address
  } mtbStrobe_t;

endpackage

// File: rtl/mtb_datapath.sv
module mtb_datapath
  import mtb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  mtbStrobe_t         strobe,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic               fetchValid,
  input  logic [PC_W-1:0]    fetchPc,
  input  logic [PC_W-1:0]    updPc,
  input  logic [PC_W-1:0]    updTarget,
  input  logic [PC_W-1:0]    ovrPc,
  output logic               lookupHit,
  output logic [PC_W-1:0]    lookupTarget,
  output logic [ENTRIES-1:0] fetchMatch,
  output logic [ENTRIES-1:0] updMatch,
  output logic [ENTRIES-1:0] validVec
);

  logic [PC_W-1:0]    tagMem [ENTRIES];
  logic [PC_W-1:0]    tgtMem [ENTRIES];
  logic [ENTRIES-1:0] ovrMatch;

  // Parallel compare of every entry against the three address ports
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign fetchMatch[e] = fetchValid && validVec[e] && (tagMem[e] == fetchPc);
    assign updMatch[e]   = validVec[e] && (tagMem[e] == updPc);
    assign ovrMatch[e]   = validVec[e] && (tagMem[e] == ovrPc);
  end

  // Target selection: matches are one-hot, so an OR of masked targets suffices
  always_comb begin
    lookupTarget = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (fetchMatch[e]) lookupTarget |= tgtMem[e];
    end
  end

  assign lookupHit = |fetchMatch;

  // Valid bits: flush first, then a write, then the clears
  always_ff @(posedge clk) begin
    if (!rstN || strobe.flushAll) begin
      validVec <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (strobe.writeEntry && (wrIdx == IDX_W'(e))) begin
          validVec[e] <= 1'b1;
        end else if ((strobe.clearUpdMatch && updMatch[e]) ||
                     (strobe.clearOvrMatch && ovrMatch[e])) begin
          validVec[e] <= 1'b0;
        end
      end
    end
  end

  // Tag and target storage, not reset
  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (strobe.writeEntry && (wrIdx == IDX_W'(e))) begin
        tagMem[e] <= updPc;
        tgtMem[e] <= updTarget;
      end
    end
  end

endmodule

// File: rtl/mtb_ctrl.sv
module mtb_ctrl
  import mtb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               updValid,
  input  logic               updTaken,
  input  logic [PC_W-1:0]    updPc,
  input  logic               ovrValid,
  input  logic [PC_W-1:0]    ovrPc,
  input  logic [ENTRIES-1:0] updMatch,
  input  logic [ENTRIES-1:0] validVec,
  output mtbStrobe_t         strobe,
  output logic [IDX_W-1:0]   wrIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic             freeFound;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] hitIdx;
  logic             updHit;
  logic             ovrWins;
  logic             updAct;
  logic             replace;
  logic [IDX_W-1:0] rrPtr;

  // Lowest-numbered free entry (descending scan, last write wins)
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!validVec[e]) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(e);
      end
    end
  end

  // Encode the (one-hot) update match
  always_comb begin
    hitIdx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (updMatch[e]) hitIdx |= IDX_W'(e);
    end
  end

  assign updHit  = |updMatch;
  assign ovrWins = ovrValid && updValid && (ovrPc == updPc);
  assign updAct  = updValid && !ovrWins && !flush;
  assign replace = strobe.writeEntry && !updHit && !freeFound;

  always_comb begin
    strobe.flushAll      = flush;
    strobe.clearOvrMatch = ovrValid && !flush;
    strobe.clearUpdMatch = updAct && !updTaken;
    strobe.writeEntry    = updAct && updTaken;
    if (updHit)         wrIdx = hitIdx;
    else if (freeFound) wrIdx = freeIdx;
    else                wrIdx = rrPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      rrPtr <= '0;
    end else if (replace) begin
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

endmodule

// File: rtl/micro_target_buffer.sv
module micro_target_buffer
  import mtb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fetchValid,
  input  logic [PC_W-1:0] fetchPc,
  output logic            lookupHit,
  output logic [PC_W-1:0] lookupTarget,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic [PC_W-1:0] updTarget,
  input  logic            updTaken,
  input  logic            ovrValid,
  input  logic [PC_W-1:0] ovrPc,
  input  logic            flush
);

  localparam int IDX_W = $clog2(ENTRIES);

  mtbStrobe_t         strobe;
  logic [IDX_W-1:0]   wrIdx;
  logic [ENTRIES-1:0] fetchMatch;
  logic [ENTRIES-1:0] updMatch;
  logic [ENTRIES-1:0] validVec;

  mtb_ctrl #(.ENTRIES(ENTRIES), .PC_W(PC_W), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flush),
    .updValid (updValid),
    .updTaken (updTaken),
    .updPc    (updPc),
    .ovrValid (ovrValid),
    .ovrPc    (ovrPc),
    .updMatch (updMatch),
    .validVec (validVec),
    .strobe   (strobe),
    .wrIdx    (wrIdx)
  );

  mtb_datapath #(.ENTRIES(ENTRIES), .PC_W(PC_W), .IDX_W(IDX_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrIdx        (wrIdx),
    .fetchValid   (fetchValid),
    .fetchPc      (fetchPc),
    .updPc        (updPc),
    .updTarget    (updTarget),
    .ovrPc        (ovrPc),
    .lookupHit    (lookupHit),
    .lookupTarget (lookupTarget),
    .fetchMatch   (fetchMatch),
    .updMatch     (updMatch),
    .validVec     (validVec)
  );

endmodule

// File: rtl/mtb_checker.sv
module mtb_checker #(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               fetchValid,
  input logic [PC_W-1:0]    fetchPc,
  input logic               lookupHit,
  input logic [PC_W-1:0]    lookupTarget,
  input logic               updValid,
  input logic [PC_W-1:0]    updPc,
  input logic [PC_W-1:0]    updTarget,
  input logic               updTaken,
  input logic               ovrValid,
  input logic [PC_W-1:0]    ovrPc,
  input logic               flush,
  input logic [ENTRIES-1:0] fetchMatch,
  input logic [ENTRIES-1:0] updMatch,
  input logic [ENTRIES-1:0] validVec
);

  // R1
  empty_after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (validVec == '0));

  // R2
  hit_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupHit |-> fetchValid);

  // R2
  single_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fetchMatch));

  // R3
  taken_learned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updTaken && !flush && !(ovrValid && ovrPc == updPc))
      ##1 (fetchValid && fetchPc == $past(updPc))
      |-> (lookupHit && lookupTarget == $past(updTarget)));

  // R4
  not_taken_no_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updTaken) |=> ($countones(validVec) <= $countones($past(validVec))));

  // R5
  no_duplicate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(updMatch));

  // R6
  not_taken_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updTaken) ##1 (fetchValid && fetchPc == $past(updPc)) |-> !lookupHit);

  // R7
  override_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovrValid ##1 (fetchValid && fetchPc == $past(ovrPc)) |-> !lookupHit);

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (validVec == '0));

endmodule

bind micro_target_buffer mtb_checker #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_mtb_chk (
  .clk          (clk),
  .rstN         (rstN),
  .fetchValid   (fetchValid),
  .fetchPc      (fetchPc),
  .lookupHit    (lookupHit),
  .lookupTarget (lookupTarget),
  .updValid     (updValid),
  .updPc        (updPc),
  .updTarget    (updTarget),
  .updTaken     (updTaken),
  .ovrValid     (ovrValid),
  .ovrPc        (ovrPc),
  .flush        (flush),
  .fetchMatch   (fetchMatch),
  .updMatch     (updMatch),
  .validVec     (validVec)
);

// File: tb/micro_target_buffer_bench.sv
module micro_target_buffer_bench;

  localparam int N  = 64;
  localparam int PW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          fetchValid = 1'b0;
  logic [PW-1:0] fetchPc = '0;
  logic          lookupHit;
  logic [PW-1:0] lookupTarget;
  logic          updValid = 1'b0;
  logic [PW-1:0] updPc = '0;
  logic [PW-1:0] updTarget = '0;
  logic          updTaken = 1'b0;
  logic          ovrValid = 1'b0;
  logic [PW-1:0] ovrPc = '0;
  logic          flush = 1'b0;

  micro_target_buffer #(.ENTRIES(N), .PC_W(PW)) u_micro_target_buffer (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .lookupHit(lookupHit), .lookupTarget(lookupTarget),
    .updValid(updValid), .updPc(updPc), .updTarget(updTarget), .updTaken(updTaken),
    .ovrValid(ovrValid), .ovrPc(ovrPc), .flush(flush)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  string curReq = "R1";

  // Behavioural reference model
  bit            mValid [N];
  logic [PW-1:0] mTag   [N];
  logic [PW-1:0] mTgt   [N];
  int            mPtr = 0;

  function automatic int findPc(logic [PW-1:0] pc);
    for (int e = 0; e < N; e++) if (mValid[e] && mTag[e] == pc) return e;
    return -1;
  endfunction

  function automatic int firstFree();
    for (int e = 0; e < N; e++) if (!mValid[e]) return e;
    return -1;
  endfunction

  task automatic modelStep();
    int uIdx, oIdx, fIdx, w;
    if (!rstN || flush) begin
      for (int e = 0; e < N; e++) mValid[e] = 0;
      mPtr = 0;
      return;
    end
    uIdx = findPc(updPc);
    oIdx = findPc(ovrPc);
    fIdx = firstFree();
    if (ovrValid && oIdx >= 0) mValid[oIdx] = 0;
    if (updValid && !(ovrValid && ovrPc == updPc)) begin
      if (updTaken) begin
        if (uIdx >= 0) w = uIdx;
        else if (fIdx >= 0) w = fIdx;
        else begin
          w = mPtr;
          mPtr = (mPtr + 1) % N;
        end
        mValid[w] = 1;
        mTag[w]   = updPc;
        mTgt[w]   = updTarget;
      end else if (uIdx >= 0) begin
        mValid[uIdx] = 0;
      end
    end
  endtask

  // One cycle: inputs already driven after a falling edge
  task automatic tick();
    int idx;
    bit expHit;
    logic [PW-1:0] expTgt;
    #2;
    idx    = findPc(fetchPc);
    expHit = fetchValid && rstN && idx >= 0;
    expTgt = expHit ? mTgt[idx] : '0;
    checks++;
    if (lookupHit !== expHit || (expHit && lookupTarget !== expTgt)) begin
      fails++;
      $display("FAIL %s pc=%h hit=%b tgt=%h expected hit=%b tgt=%h",
               curReq, fetchPc, lookupHit, lookupTarget, expHit, expTgt);
    end
    @(posedge clk);
    modelStep();
    @(negedge clk);
    fetchValid = 0; updValid = 0; updTaken = 0; ovrValid = 0; flush = 0;
  endtask

  task automatic look(logic [PW-1:0] pc);
    fetchValid = 1; fetchPc = pc;
    tick();
  endtask

  task automatic upd(logic [PW-1:0] pc, logic [PW-1:0] tgt, logic tk);
    updValid = 1; updPc = pc; updTarget = tgt; updTaken = tk;
    tick();
  endtask

  function automatic logic [PW-1:0] gpc(int k);
    return 32'h2000_0000 + PW'(k) * 4;
  endfunction

  function automatic logic [PW-1:0] gtg(int k);
    return 32'h8000_0000 ^ (PW'(k) * 32'h0001_0113);
  endfunction

  task automatic sweep(int lo, int hi);
    for (int k = lo; k <= hi; k++) look(gpc(k));
  endtask

  bit done = 0;

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired in %s", curReq);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset dominates a concurrent taken update
    curReq = "R1";
    for (int c = 0; c < 3; c++) begin
      updValid = 1; updPc = gpc(1); updTarget = gtg(1); updTaken = 1;
      fetchValid = 1; fetchPc = gpc(1);
      tick();
    end
    rstN = 1;
    look(gpc(1));
    look(gpc(0));

    // R3: allocation into free entries, visible next cycle
    curReq = "R3";
    for (int k = 0; k < 5; k++) upd(gpc(k), gtg(k), 1);
    sweep(0, 5);
    // same-cycle lookup of the address being written still sees old state
    fetchValid = 1; fetchPc = gpc(6);
    updValid = 1; updPc = gpc(6); updTarget = gtg(6); updTaken = 1;
    tick();
    look(gpc(6));

    // R2: no hit without fetchValid
    curReq = "R2";
    fetchValid = 0; fetchPc = gpc(1);
    tick();
    look(gpc(2));

    // R4: not-taken for absent address makes nothing
    curReq = "R4";
    upd(gpc(40), gtg(40), 0);
    look(gpc(40));

    // R5: rewrite of a stored target
    curReq = "R5";
    upd(gpc(2), 32'hCAFE_0000, 1);
    look(gpc(2));

    // R6: not-taken for a stored address invalidates it
    curReq = "R6";
    upd(gpc(3), gtg(3), 0);
    look(gpc(3));
    look(gpc(4));

    // R7: override, and override beating an update for the same address
    curReq = "R7";
    ovrValid = 1; ovrPc = gpc(4);
    tick();
    look(gpc(4));
    ovrValid = 1; ovrPc = gpc(0);
    updValid = 1; updPc = gpc(0); updTarget = 32'h1234_5678; updTaken = 1;
    tick();
    look(gpc(0));
    ovrValid = 1; ovrPc = gpc(1);
    updValid = 1; updPc = gpc(7); updTarget = gtg(7); updTaken = 1;
    tick();
    sweep(0, 8);

    // R9: flush wins over a concurrent update
    curReq = "R9";
    flush = 1;
    updValid = 1; updPc = gpc(9); updTarget = gtg(9); updTaken = 1;
    tick();
    sweep(0, 9);

    // R5: repeated updates of one address create a single entry
    curReq = "R5";
    for (int r = 0; r < 10; r++) upd(gpc(100), gtg(r), 1);
    for (int k = 101; k < 164; k++) upd(gpc(k), gtg(k), 1);
    sweep(100, 163);

    // R8: round-robin replacement once full
    curReq = "R8";
    for (int k = 164; k < 167; k++) upd(gpc(k), gtg(k), 1);
    sweep(100, 166);
    upd(gpc(110), gtg(110), 0);
    upd(gpc(170), gtg(170), 1);
    upd(gpc(171), gtg(171), 1);
    sweep(100, 171);
    for (int k = 200; k < 270; k++) upd(gpc(k), gtg(k), 1);
    sweep(100, 171);
    sweep(200, 269);

    // R9: pointer returns to entry 0 after flush
    curReq = "R9";
    flush = 1;
    tick();
    for (int k = 300; k < 366; k++) upd(gpc(k), gtg(k), 1);
    sweep(300, 365);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule